// File: doc/BRIEF.md
# Tag Check Fault Responder

This block takes the result of a memory tag comparison and decides what happens next. Each cycle it can accept one checked access event. The event carries the access address, a write flag, a tag-mismatch flag and a log2 alignment requirement. It also carries the translation context of the access: whether the regime is user level, whether it splits the address space into two ranges, and which exception level owns it. The 64-bit system control word for that regime comes in alongside.

An access whose address violates a non-zero alignment requirement always produces an alignment abort, and its tag result is then ignored. Otherwise a tag mismatch is handled by a 2-bit fault mode taken from the control word. The mode can drop the failure, raise a synchronous abort, or record the failure in a sticky per-level status register. A fourth, asymmetric mode records failing stores and aborts on failing loads.

Aborts appear as a single-cycle pulse one clock after the event, with the address and write flag held in registers. Software reads the status registers through a combinational read port and clears them through a write port.

Top module: `tag_fault_responder`

## Requirements
- R1: After reset `abort_pulse` is 0 and every status register reads 0.
- R2: For user-level regimes (`rg_user`=1) the fault mode is `sys_ctrl[39:38]`; for all other regimes it is `sys_ctrl[41:40]`. Mode values: 0 ignore, 1 abort, 2 record, 3 asymmetric.
- R3: In mode 0 a tag mismatch produces no abort and leaves every status register unchanged.
- R4: In mode 1 a tag mismatch makes `abort_pulse` high for exactly the cycle after the event. In that cycle `abort_align`=0, `abort_addr` equals the event address and `abort_write` equals the event write flag.
- R5: In mode 2 a tag mismatch sets one sticky bit in status register `rg_el` and produces no abort.
- R6: In mode 3 a failing write behaves as in mode 2, and a failing read behaves as in mode 1.
- R7: The recorded status bit is bit `evt_addr[55]` when `rg_two_ranges`=1, and bit 0 otherwise.
- R8: When `evt_align_lg2` is non-zero and any of the address bits below 2^`evt_align_lg2` is set, the event yields an abort with `abort_align`=1 in the next cycle, whatever the tag flag or mode. The tag outcome is then suppressed, so no status bit is set. An alignment field of 0 never aborts.
- R9: Each event yields at most one outcome: one abort pulse, one status bit set, or nothing.
- R10: Status bits stay set until a software write to that register. The write replaces the register with `sw_wr_data`, and a hardware set to the same register in the same cycle is ORed on top of that value.
- R11: `sw_rd_data` shows status register `sw_rd_el` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A checked access event is present |
| evt_addr | input | ADDR_W | Address of the access |
| evt_write | input | 1 | 1 for a store, 0 for a load |
| evt_tag_mismatch | input | 1 | Tag comparison failed |
| evt_align_lg2 | input | ALIGN_W | Log2 of the required alignment, 0 for none |
| rg_user | input | 1 | Regime is user level |
| rg_two_ranges | input | 1 | Regime has two address ranges |
| rg_el | input | EL_W | Exception level owning the regime |
| sys_ctrl | input | 64 | System control word of that regime |
| sw_wr_en | input | 1 | Software write to a status register |
| sw_wr_el | input | EL_W | Status register written |
| sw_wr_data | input | 2 | Value written |
| sw_rd_el | input | EL_W | Status register read |
| sw_rd_data | output | 2 | Value of the read register |
| abort_pulse | output | 1 | Synchronous abort request, one cycle |
| abort_align | output | 1 | Abort cause: 1 alignment, 0 tag |
| abort_addr | output | ADDR_W | Address of the faulting access |
| abort_write | output | 1 | Write flag of the faulting access |

## Verification
On every cycle the assertions check the following. Every abort traces back to an event one cycle earlier and carries that event's address and write flag. An alignment abort needs a non-zero alignment field. A record and an abort never both follow from one event. A tag abort or a status change never follows an event in mode 0. Status bits never clear unless software writes them.

Only the bench scenarios can show the rest:
- which control bits select the mode for each regime type;
- the asymmetric split between loads and stores;
- the bit-55 selection of the status bit;
- the override of a hardware set by a simultaneous software write.

The bench shows these by comparing each outcome with a model computed from the requirements.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  typedef enum logic [1:0] {
    FM_IGNORE = 2'd0,
    FM_ABORT  = 2'd1,
    FM_RECORD = 2'd2,
    FM_ASYM   = 2'd3
  } fault_mode_e;

  localparam int USER_MODE_LSB = 38;
  localparam int PRIV_MODE_LSB = 40;
  localparam int STAT_W        = 2;

  function automatic fault_mode_e pick_mode(input logic [63:0] ctrl, input logic user);
    return user ? fault_mode_e'(ctrl[USER_MODE_LSB +: 2])
                : fault_mode_e'(ctrl[PRIV_MODE_LSB +: 2]);
  endfunction
endpackage

// File: rtl/tfr_align_chk.sv
module tfr_align_chk #(
  parameter int ADDR_W  = 64,
  parameter int ALIGN_W = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ALIGN_W-1:0] lg2,
  output logic               misaligned
);
  localparam int SPAN = (1 << ALIGN_W) - 1;

  logic [SPAN-1:0] low_mask;

  always_comb begin
    for (int b = 0; b < SPAN; b++) begin
      low_mask[b] = (b < int'(lg2));
    end
    misaligned = |(addr[SPAN-1:0] & low_mask);
  end
endmodule

// File: rtl/tfr_outcome.sv
module tfr_outcome #(
  parameter int ADDR_W  = 64,
  parameter int SEL_BIT = 55
) (
  input  logic                 evt_valid,
  input  logic                 evt_write,
  input  logic                 evt_tag_mismatch,
  input  logic                 align_hit,
  input  logic [ADDR_W-1:0]    evt_addr,
  input  logic                 rg_user,
  input  logic                 rg_two_ranges,
  input  logic [63:0]          sys_ctrl,
  output tfr_pkg::fault_mode_e mode,
  output logic                 take_abort,
  output logic                 take_record,
  output logic [1:0]           record_mask
);
  import tfr_pkg::*;

  logic tag_evt;
  logic bit_idx;

  always_comb begin
    mode    = pick_mode(sys_ctrl, rg_user);
    tag_evt = evt_valid && !align_hit && evt_tag_mismatch;
    bit_idx = rg_two_ranges ? evt_addr[SEL_BIT] : 1'b0;
    take_abort  = tag_evt && ((mode == FM_ABORT)  || (mode == FM_ASYM && !evt_write));
    take_record = tag_evt && ((mode == FM_RECORD) || (mode == FM_ASYM &&  evt_write));
    record_mask = take_record ? (bit_idx ? 2'b10 : 2'b01) : 2'b00;
  end
endmodule

// File: rtl/tfr_status_bank.sv
module tfr_status_bank #(
  parameter int NUM_EL = 4,
  localparam int EL_W = (NUM_EL > 1) ? $clog2(NUM_EL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [EL_W-1:0] set_el,
  input  logic [1:0]      set_mask,
  input  logic            wr_en,
  input  logic [EL_W-1:0] wr_el,
  input  logic [1:0]      wr_data,
  input  logic [EL_W-1:0] rd_el,
  output logic [1:0]      rd_data
);
  logic [1:0] stat [NUM_EL];

  for (genvar e = 0; e < NUM_EL; e++) begin : g_el
    logic hit_wr, hit_set;
    assign hit_wr  = wr_en  && (wr_el  == EL_W'(e));
    assign hit_set = set_en && (set_el == EL_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n)
        stat[e] <= '0;
      else if (hit_wr || hit_set)
        stat[e] <= (hit_wr ? wr_data : stat[e]) | (hit_set ? set_mask : 2'b00);
    end
  end

  always_comb begin
    rd_data = '0;
    for (int e = 0; e < NUM_EL; e++)
      if (rd_el == EL_W'(e)) rd_data = stat[e];
  end
endmodule

// File: rtl/tag_fault_responder.sv
module tag_fault_responder #(
  parameter int ADDR_W  = 64,
  parameter int ALIGN_W = 3,
  parameter int NUM_EL  = 4,
  parameter int SEL_BIT = 55,
  localparam int EL_W = (NUM_EL > 1) ? $clog2(NUM_EL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic [ADDR_W-1:0]  evt_addr,
  input  logic               evt_write,
  input  logic               evt_tag_mismatch,
  input  logic [ALIGN_W-1:0] evt_align_lg2,
  input  logic               rg_user,
  input  logic               rg_two_ranges,
  input  logic [EL_W-1:0]    rg_el,
  input  logic [63:0]        sys_ctrl,
  input  logic               sw_wr_en,
  input  logic [EL_W-1:0]    sw_wr_el,
  input  logic [1:0]         sw_wr_data,
  input  logic [EL_W-1:0]    sw_rd_el,
  output logic [1:0]         sw_rd_data,
  output logic               abort_pulse,
  output logic               abort_align,
  output logic [ADDR_W-1:0]  abort_addr,
  output logic               abort_write
);
  import tfr_pkg::*;

  logic        misaligned;
  logic        align_hit;
  fault_mode_e mode;
  logic        take_abort;
  logic        take_record;
  logic [1:0]  record_mask;

  tfr_align_chk #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_align (
    .addr(evt_addr), .lg2(evt_align_lg2), .misaligned(misaligned)
  );

  assign align_hit = evt_valid && misaligned;

  tfr_outcome #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)) u_outcome (
    .evt_valid(evt_valid), .evt_write(evt_write), .evt_tag_mismatch(evt_tag_mismatch),
    .align_hit(align_hit), .evt_addr(evt_addr), .rg_user(rg_user),
    .rg_two_ranges(rg_two_ranges), .sys_ctrl(sys_ctrl), .mode(mode),
    .take_abort(take_abort), .take_record(take_record), .record_mask(record_mask)
  );

  tfr_status_bank #(.NUM_EL(NUM_EL)) u_status (
    .clk(clk), .rst_n(rst_n), .set_en(take_record), .set_el(rg_el),
    .set_mask(record_mask), .wr_en(sw_wr_en), .wr_el(sw_wr_el),
    .wr_data(sw_wr_data), .rd_el(sw_rd_el), .rd_data(sw_rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_pulse <= 1'b0;
      abort_align <= 1'b0;
      abort_addr  <= '0;
      abort_write <= 1'b0;
    end else begin
      abort_pulse <= align_hit || take_abort;
      if (align_hit || take_abort) begin
        abort_align <= align_hit;
        abort_addr  <= evt_addr;
        abort_write <= evt_write;
      end
    end
  end
endmodule

// File: rtl/tfr_checker.sv
module tfr_checker #(
  parameter int ADDR_W  = 64,
  parameter int ALIGN_W = 3,
  parameter int EL_W    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evt_valid,
  input logic [ADDR_W-1:0]  evt_addr,
  input logic               evt_write,
  input logic               evt_tag_mismatch,
  input logic [ALIGN_W-1:0] evt_align_lg2,
  input logic [1:0]         mode,
  input logic               align_hit,
  input logic               take_record,
  input logic               sw_wr_en,
  input logic [EL_W-1:0]    sw_rd_el,
  input logic [1:0]         sw_rd_data,
  input logic               abort_pulse,
  input logic               abort_align,
  input logic [ADDR_W-1:0]  abort_addr,
  input logic               abort_write
);
  // R4, R8: every abort comes from an event in the cycle before
  a_r4_abort_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> $past(evt_valid));

  // R4: registered address and write flag match the event
  a_r4_abort_payload: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (abort_addr == $past(evt_addr) && abort_write == $past(evt_write)));

  // R8: alignment abort requires a non-zero alignment field
  a_r8_align_needs_field: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && abort_align) |-> ($past(evt_align_lg2) != '0));

  // R9: a recorded failure never also aborts
  a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    take_record |=> !abort_pulse);

  // R3: mode 0 tag failure neither aborts nor records
  a_r3_ignore_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_tag_mismatch && !align_hit && mode == 2'd0) |=> !abort_pulse);

  a_r3_ignore_no_record: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && mode == 2'd0) |-> !take_record);

  // R10: without a software write, a visible set bit stays set
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sw_wr_en) && $stable(sw_rd_el)) |-> ((sw_rd_data & $past(sw_rd_data)) == $past(sw_rd_data)));
endmodule

bind tag_fault_responder tfr_checker #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .EL_W(EL_W)) u_tfr_checker (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_addr(evt_addr),
  .evt_write(evt_write), .evt_tag_mismatch(evt_tag_mismatch),
  .evt_align_lg2(evt_align_lg2), .mode(mode), .align_hit(align_hit),
  .take_record(take_record), .sw_wr_en(sw_wr_en), .sw_rd_el(sw_rd_el),
  .sw_rd_data(sw_rd_data), .abort_pulse(abort_pulse), .abort_align(abort_align),
  .abort_addr(abort_addr), .abort_write(abort_write)
);

// File: tb/tag_fault_responder_test.sv
module tag_fault_responder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [63:0] evt_addr = '0;
  logic        evt_write = 1'b0;
  logic        evt_tag_mismatch = 1'b0;
  logic [2:0]  evt_align_lg2 = '0;
  logic        rg_user = 1'b0;
  logic        rg_two_ranges = 1'b0;
  logic [1:0]  rg_el = '0;
  logic [63:0] sys_ctrl = '0;
  logic        sw_wr_en = 1'b0;
  logic [1:0]  sw_wr_el = '0;
  logic [1:0]  sw_wr_data = '0;
  logic [1:0]  sw_rd_el = '0;
  logic [1:0]  sw_rd_data;
  logic        abort_pulse, abort_align, abort_write;
  logic [63:0] abort_addr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [1:0] mstat [4];

  typedef struct {
    int          due;
    bit          pulse;
    bit          align;
    logic [63:0] addr;
    bit          wr;
    string       req;
  } exp_t;
  exp_t q[$];

  tag_fault_responder uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_addr(evt_addr),
    .evt_write(evt_write), .evt_tag_mismatch(evt_tag_mismatch),
    .evt_align_lg2(evt_align_lg2), .rg_user(rg_user), .rg_two_ranges(rg_two_ranges),
    .rg_el(rg_el), .sys_ctrl(sys_ctrl), .sw_wr_en(sw_wr_en), .sw_wr_el(sw_wr_el),
    .sw_wr_data(sw_wr_data), .sw_rd_el(sw_rd_el), .sw_rd_data(sw_rd_data),
    .abort_pulse(abort_pulse), .abort_align(abort_align), .abort_addr(abort_addr),
    .abort_write(abort_write)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops scoreboard items when due
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (abort_pulse !== e.pulse ||
            (e.pulse && (abort_align !== e.align || abort_addr !== e.addr || abort_write !== e.wr))) begin
          fails++;
          $display("FAIL %s: pulse/align/addr/wr = %b/%b/%h/%b expected %b/%b/%h/%b",
                   e.req, abort_pulse, abort_align, abort_addr, abort_write,
                   e.pulse, e.align, e.addr, e.wr);
        end
      end else if (abort_pulse) begin
        checks++; fails++;
        $display("FAIL R9: unexpected abort pulse=%b expected 0", abort_pulse);
      end
    end
  end

  // driver: call right after a negedge; returns at the next negedge
  task automatic ev(input logic [63:0] a, input bit wr, input bit mism, input logic [2:0] lg2,
                    input bit usr, input bit two, input logic [1:0] el, input string req);
    logic [1:0] m;
    bit mis;
    exp_t e;
    evt_valid = 1'b1; evt_addr = a; evt_write = wr; evt_tag_mismatch = mism;
    evt_align_lg2 = lg2; rg_user = usr; rg_two_ranges = two; rg_el = el;
    m   = usr ? sys_ctrl[39:38] : sys_ctrl[41:40];
    mis = (lg2 != 0) && ((a & ((64'd1 << lg2) - 64'd1)) != 0);
    e.due = cyc + 1; e.addr = a; e.wr = wr; e.req = req; e.align = mis;
    e.pulse = mis || (mism && (m == 2'd1 || (m == 2'd3 && !wr)));
    if (!mis && mism && (m == 2'd2 || (m == 2'd3 && wr)))
      mstat[el] = mstat[el] | ((two && a[55]) ? 2'b10 : 2'b01);
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle();
    evt_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_stat(input logic [1:0] el, input string req);
    sw_rd_el = el;
    #1;
    checks++;
    if (sw_rd_data !== mstat[el]) begin
      fails++;
      $display("FAIL %s: status[%0d]=%b expected %b", req, el, sw_rd_data, mstat[el]);
    end
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < 4; i++) chk_stat(2'(i), req);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mstat[i] = 2'b00;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (abort_pulse !== 1'b0) begin
      fails++; $display("FAIL R1: abort_pulse=%b expected 0", abort_pulse);
    end
    chk_all("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R4: user regime uses bits 39:38, mode 1 load and store
    sys_ctrl = 64'd1 << 38;
    ev(64'h0000_1234_5678_9ab0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 2'd0, "R4");
    ev(64'h00ff_0000_0000_0040, 1'b1, 1'b1, 3'd0, 1'b1, 1'b0, 2'd0, "R4");
    // R2: privileged regime ignores 39:38 (its field 41:40 is 0) -> R3 ignore
    ev(64'h0000_0000_0000_0080, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 2'd1, "R2");
    idle();
    chk_all("R3");
    // R2: privileged field 41:40 = 1 aborts, user field now 0 ignores
    sys_ctrl = 64'd1 << 40;
    ev(64'h0000_0000_0000_0100, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 2'd1, "R2");
    ev(64'h0000_0000_0000_0110, 1'b1, 1'b1, 3'd0, 1'b1, 1'b0, 2'd1, "R2");
    // no mismatch: nothing happens
    ev(64'h0000_0000_0000_0120, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 2'd1, "R9");
    idle();
    chk_all("R3");

    // R5, R7: record mode with one and two ranges
    sys_ctrl = (64'd2 << 40) | (64'd2 << 38);
    ev(64'h0080_0000_0000_0000, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 2'd2, "R7");
    idle();
    chk_stat(2'd2, "R7");
    ev(64'h0080_0000_0000_0000, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 2'd3, "R5");
    ev(64'h0000_0000_0000_0000, 1'b0, 1'b1, 3'd0, 1'b1, 1'b1, 2'd2, "R7");
    idle();
    chk_all("R5");

    // R10: software write clears, status stays otherwise
    sw_wr_en = 1'b1; sw_wr_el = 2'd2; sw_wr_data = 2'b00;
    @(negedge clk);
    sw_wr_en = 1'b0;
    mstat[2] = 2'b00;
    chk_stat(2'd2, "R10");
    chk_stat(2'd3, "R10");
    // R10: simultaneous write and hardware set on same register
    sw_wr_en = 1'b1; sw_wr_el = 2'd3; sw_wr_data = 2'b10;
    mstat[3] = 2'b10;
    ev(64'h0000_0000_0000_0200, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 2'd3, "R10");
    sw_wr_en = 1'b0;
    idle();
    chk_stat(2'd3, "R10");

    // R6: asymmetric mode
    sys_ctrl = 64'd3 << 40;
    ev(64'h0080_0000_0000_0300, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 2'd1, "R6");
    ev(64'h0080_0000_0000_0310, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 2'd1, "R6");
    idle();
    chk_stat(2'd1, "R6");

    // R8: alignment faults
    ev(64'h0000_0000_0000_0404, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0, 2'd0, "R8");
    ev(64'h0000_0000_0000_0401, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 2'd0, "R8");
    ev(64'h0000_0000_0000_0440, 1'b0, 1'b0, 3'd7, 1'b0, 1'b0, 2'd0, "R8");
    ev(64'h0000_0000_0000_0408, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 2'd0, "R8");
    ev(64'h0000_0000_0000_0407, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 2'd0, "R8");
    idle();
    chk_all("R8");
    // R11: read port follows sw_rd_el
    chk_stat(2'd1, "R11");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R4: %0d outcomes never observed, expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule